// File: doc/BRIEF.md
# Output Port Predictor Bank

This block sits beside one input channel of a five-port mesh router. It guesses which output port the next packet head on that channel will leave through. With that guess the router can reserve a crossbar path before the head arrives. The prediction is presented at all times as a one-hot vector over the ports X+, X-, Y+, Y- and local. Each time a head flit's real route becomes known, the router reports it on `route_valid` / `route_port`, and every predictor updates its history from that report.

Four predictors run side by side on the same history:

- **Straight:** keeps the packet moving in its direction of travel.
- **Last port:** repeats the previous route.
- **Custom:** returns a port set by configuration.
- **Context:** looks up which port has most often followed the previously used port.

A guard rewrites any candidate that would send a packet back out of the port it entered by, or that is not a legal port code. In that case the straight choice is used instead.

In static mode a configuration field picks the active predictor directly. In dynamic mode a selector counts hits for every predictor. At the end of each fixed window of cycles it makes the best scorer active.

Top module: `opb_predictor_bank`

## Requirements
- R1: `pred_oh` always has exactly one bit set. Bit i stands for port code i, where 0 = X+, 1 = X-, 2 = Y+, 3 = Y- and 4 = local.
- R2: The straight prediction maps input code 0 to 1, 1 to 0, 2 to 3 and 3 to 2. For input code 4 it is `cfg_local_port`, or code 0 when that field holds 4 or a code above 4.
- R3: The last-port prediction is the port of the most recent head reported on `route_valid`. Before any report since reset it equals the straight prediction.
- R4: The custom prediction is `cfg_custom_port`.
- R5: The context prediction is the port reported most often directly after the currently previous port. Ties go to the lowest code, and an all-zero row gives code 0. Each pair count saturates at 2^CTX_W-1. With no report since reset the context prediction is the straight one.
- R6: A candidate equal to `cfg_in_dir`, or above 4, is replaced by the straight prediction. The output therefore never selects the input's own port.
- R7: When `cfg_dynamic` is 0, `cfg_static_sel` picks the predictor: 0 straight, 1 last port, 2 custom, 3 context. A change of configuration reaches `pred_oh` combinationally, within the same cycle.
- R8: Each predictor's hit count grows by one, saturating at 2^HIT_W-1, on every `route_valid` cycle where its guarded prediction equals `route_port`. On the WINDOW-th cycle after reset and on every WINDOW-th cycle after that, the highest count becomes the active predictor in dynamic mode from the next cycle on, with ties going to the lowest predictor code. That cycle's hits then start the new window's counts.
- R9: Reset clears all history and counts, restarts the window, and makes straight the active dynamic predictor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_in_dir | input | 3 | Port code of the input channel this bank serves |
| cfg_dynamic | input | 1 | 1 selects by hit counting, 0 by `cfg_static_sel` |
| cfg_static_sel | input | 2 | Predictor code used in static mode |
| cfg_custom_port | input | 3 | Port returned by the custom predictor |
| cfg_local_port | input | 3 | Straight prediction for the local input |
| route_valid | input | 1 | A head flit's actual route is reported this cycle |
| route_port | input | 3 | Port code of that actual route |
| pred_oh | output | 5 | One-hot predicted output port |

## Verification
The hardest situation to reach is a dynamic window boundary where several hit counts are saturated and tied, and the chosen predictor agrees with a loser on the current port. The bench reaches it with a short window and narrow counters. It counts edges from the release of reset so that a burst of identical routes fills the counters before the boundary. It then changes the custom port just before the boundary, so that the output differs depending on which predictor won. The context saturation case is reached in a similar way: a route sequence drives one pair count to its limit, and then increments it once more, so that a wrapped count would flip the argmax.

// File: rtl/opb_pkg.sv
package opb_pkg;
    localparam int NPORT = 5;
    localparam int PW    = 3;
    localparam int NPRED = 4;
    localparam int SW    = 2;

    typedef logic [PW-1:0]    port_t;
    typedef logic [NPORT-1:0] port_oh_t;
    typedef port_t [NPRED-1:0] pred_vec_t;

    typedef enum logic [SW-1:0] {
        PR_STRAIGHT = 2'd0,
        PR_LAST     = 2'd1,
        PR_CUSTOM   = 2'd2,
        PR_CONTEXT  = 2'd3
    } pred_e;

    localparam port_t P_XP  = 3'd0;
    localparam port_t P_XN  = 3'd1;
    localparam port_t P_YP  = 3'd2;
    localparam port_t P_YN  = 3'd3;
    localparam port_t P_LOC = 3'd4;

    typedef struct packed {
        logic  vld;
        port_t port;
    } hist_t;

    function automatic logic port_ok(port_t p);
        return p < port_t'(NPORT);
    endfunction

    function automatic port_t straight_of(port_t in_dir, port_t loc_dflt);
        port_t r;
        case (in_dir)
            P_XP:    r = P_XN;
            P_XN:    r = P_XP;
            P_YP:    r = P_YN;
            P_YN:    r = P_YP;
            default: r = (port_ok(loc_dflt) && loc_dflt != P_LOC) ? loc_dflt : P_XP;
        endcase
        return r;
    endfunction

    function automatic port_t guard_port(port_t cand, port_t in_dir, port_t loc_dflt);
        if (!port_ok(cand) || cand == in_dir)
            return straight_of(in_dir, loc_dflt);
        return cand;
    endfunction

    function automatic port_oh_t to_onehot(port_t p);
        port_oh_t r;
        for (int i = 0; i < NPORT; i++)
            r[i] = (p == port_t'(i));
        return r;
    endfunction
endpackage

// File: rtl/opb_basic_preds.sv
module opb_basic_preds
    import opb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  port_t in_dir,
    input  port_t loc_dflt,
    input  port_t custom_port,
    input  logic  route_valid,
    input  port_t route_port,
    output port_t straight_p,
    output port_t last_p,
    output port_t custom_p
);
    hist_t last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
        end else if (route_valid) begin
            last_q.vld  <= port_ok(route_port);
            last_q.port <= route_port;
        end
    end

    always_comb begin
        straight_p = straight_of(in_dir, loc_dflt);
        last_p     = last_q.vld ? guard_port(last_q.port, in_dir, loc_dflt) : straight_p;
        custom_p   = guard_port(custom_port, in_dir, loc_dflt);
    end
endmodule

// File: rtl/opb_ctx_pred.sv
module opb_ctx_pred
    import opb_pkg::*;
#(
    parameter int CTX_W = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  port_t in_dir,
    input  port_t loc_dflt,
    input  logic  route_valid,
    input  port_t route_port,
    output port_t ctx_p
);
    localparam logic [CTX_W-1:0] CMAX = {CTX_W{1'b1}};

    hist_t            prev_q;
    logic [CTX_W-1:0] cnt     [NPORT][NPORT];
    logic [CTX_W-1:0] row_cnt [NPORT];
    logic [CTX_W-1:0] best_v;
    port_t            best_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            for (int r = 0; r < NPORT; r++)
                for (int c = 0; c < NPORT; c++)
                    cnt[r][c] <= '0;
        end else if (route_valid) begin
            prev_q.vld  <= port_ok(route_port);
            prev_q.port <= route_port;
            for (int r = 0; r < NPORT; r++)
                for (int c = 0; c < NPORT; c++)
                    if (prev_q.vld && prev_q.port == port_t'(r) &&
                        route_port == port_t'(c) && cnt[r][c] != CMAX)
                        cnt[r][c] <= cnt[r][c] + 1'b1;
        end
    end

    always_comb begin
        for (int c = 0; c < NPORT; c++)
            row_cnt[c] = '0;
        for (int r = 0; r < NPORT; r++)
            if (prev_q.port == port_t'(r))
                for (int c = 0; c < NPORT; c++)
                    row_cnt[c] = cnt[r][c];
    end

    always_comb begin
        best_p = P_XP;
        best_v = row_cnt[0];
        for (int c = 1; c < NPORT; c++) begin
            if (row_cnt[c] > best_v) begin
                best_v = row_cnt[c];
                best_p = port_t'(c);
            end
        end
        ctx_p = prev_q.vld ? guard_port(best_p, in_dir, loc_dflt)
                           : straight_of(in_dir, loc_dflt);
    end
endmodule

// File: rtl/opb_hit_selector.sv
module opb_hit_selector
    import opb_pkg::*;
#(
    parameter int WINDOW = 10000,
    parameter int HIT_W  = 14
) (
    input  logic                        clk,
    input  logic                        rst,
    input  pred_vec_t                   preds,
    input  logic                        route_valid,
    input  port_t                       route_port,
    output pred_e                       dyn_sel,
    output logic                        win_last,
    output logic [NPRED-1:0][HIT_W-1:0] hit_cnt
);
    localparam int WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [WIN_W-1:0] WIN_END = WIN_W'(WINDOW - 1);
    localparam logic [HIT_W-1:0] HMAX = {HIT_W{1'b1}};

    logic [WIN_W-1:0] win_cnt;
    logic [NPRED-1:0] hit;
    pred_e            best;
    logic [HIT_W-1:0] best_v;

    assign win_last = (win_cnt == WIN_END);

    always_comb begin
        for (int k = 0; k < NPRED; k++)
            hit[k] = route_valid && (preds[k] == route_port);
    end

    always_comb begin
        best   = PR_STRAIGHT;
        best_v = hit_cnt[0];
        for (int k = 1; k < NPRED; k++) begin
            if (hit_cnt[k] > best_v) begin
                best_v = hit_cnt[k];
                best   = pred_e'(SW'(k));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= '0;
            dyn_sel <= PR_STRAIGHT;
            hit_cnt <= '0;
        end else begin
            win_cnt <= win_last ? '0 : win_cnt + 1'b1;
            if (win_last)
                dyn_sel <= best;
            for (int k = 0; k < NPRED; k++) begin
                if (win_last)
                    hit_cnt[k] <= hit[k] ? HIT_W'(1) : '0;
                else if (hit[k] && hit_cnt[k] != HMAX)
                    hit_cnt[k] <= hit_cnt[k] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/opb_predictor_bank.sv
module opb_predictor_bank
    import opb_pkg::*;
#(
    parameter int WINDOW = 10000,
    parameter int HIT_W  = 14,
    parameter int CTX_W  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] cfg_in_dir,
    input  logic       cfg_dynamic,
    input  logic [1:0] cfg_static_sel,
    input  logic [2:0] cfg_custom_port,
    input  logic [2:0] cfg_local_port,
    input  logic       route_valid,
    input  logic [2:0] route_port,
    output logic [4:0] pred_oh
);
    pred_vec_t                   preds;
    pred_e                       dyn_sel;
    pred_e                       active;
    logic                        win_last;
    logic [NPRED-1:0][HIT_W-1:0] hit_cnt;

    opb_basic_preds u_basic (
        .clk         (clk),
        .rst         (rst),
        .in_dir      (cfg_in_dir),
        .loc_dflt    (cfg_local_port),
        .custom_port (cfg_custom_port),
        .route_valid (route_valid),
        .route_port  (route_port),
        .straight_p  (preds[PR_STRAIGHT]),
        .last_p      (preds[PR_LAST]),
        .custom_p    (preds[PR_CUSTOM])
    );

    opb_ctx_pred #(.CTX_W(CTX_W)) u_ctx (
        .clk         (clk),
        .rst         (rst),
        .in_dir      (cfg_in_dir),
        .loc_dflt    (cfg_local_port),
        .route_valid (route_valid),
        .route_port  (route_port),
        .ctx_p       (preds[PR_CONTEXT])
    );

    opb_hit_selector #(.WINDOW(WINDOW), .HIT_W(HIT_W)) u_sel (
        .clk         (clk),
        .rst         (rst),
        .preds       (preds),
        .route_valid (route_valid),
        .route_port  (route_port),
        .dyn_sel     (dyn_sel),
        .win_last    (win_last),
        .hit_cnt     (hit_cnt)
    );

    assign active  = cfg_dynamic ? dyn_sel : pred_e'(cfg_static_sel);
    assign pred_oh = to_onehot(preds[active]);
endmodule

// File: rtl/opb_bank_chk.sv
module opb_bank_chk
    import opb_pkg::*;
#(
    parameter int HIT_W = 14
) (
    input logic                        clk,
    input logic                        rst,
    input logic [2:0]                  cfg_in_dir,
    input logic                        cfg_dynamic,
    input logic [1:0]                  cfg_static_sel,
    input logic [2:0]                  cfg_custom_port,
    input logic                        route_valid,
    input logic [4:0]                  pred_oh,
    input logic [1:0]                  dyn_sel,
    input logic                        win_last,
    input logic [NPRED-1:0][HIT_W-1:0] hit_cnt
);
    localparam logic [HIT_W-1:0] HMAX = {HIT_W{1'b1}};

    // R1
    onehot_out_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(pred_oh) == 1);

    // R6
    no_uturn_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_in_dir < 3'd5) |-> !pred_oh[cfg_in_dir]);

    // R4
    custom_static_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_dynamic && cfg_static_sel == 2'd2 && cfg_custom_port < 3'd5 &&
         cfg_custom_port != cfg_in_dir) |-> pred_oh[cfg_custom_port]);

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !win_last |=> $stable(dyn_sel));

    for (genvar k = 0; k < NPRED; k++) begin : g_cnt
        // R8
        hit_sat_chk: assert property (@(posedge clk) disable iff (rst)
            (route_valid && !win_last && hit_cnt[k] == HMAX) |=> hit_cnt[k] == HMAX);
        // R8
        hit_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (win_last && !route_valid) |=> hit_cnt[k] == '0);
    end
endmodule

bind opb_predictor_bank opb_bank_chk #(.HIT_W(HIT_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_in_dir      (cfg_in_dir),
    .cfg_dynamic     (cfg_dynamic),
    .cfg_static_sel  (cfg_static_sel),
    .cfg_custom_port (cfg_custom_port),
    .route_valid     (route_valid),
    .pred_oh         (pred_oh),
    .dyn_sel         (dyn_sel),
    .win_last        (win_last),
    .hit_cnt         (hit_cnt)
);

// File: tb/opb_predictor_bank_tb.sv
`timescale 1ns/1ps
module opb_predictor_bank_tb;
    localparam real CYC = 8.0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_in_dir = 3'd0;
    logic       cfg_dynamic = 1'b0;
    logic [1:0] cfg_static_sel = 2'd0;
    logic [2:0] cfg_custom_port = 3'd3;
    logic [2:0] cfg_local_port = 3'd2;
    logic       route_valid = 1'b0;
    logic [2:0] route_port = 3'd0;
    logic [4:0] pred_oh;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CYC/2) clk = ~clk;

    opb_predictor_bank #(.WINDOW(8), .HIT_W(2), .CTX_W(2)) u_dut (
        .clk(clk), .rst(rst), .cfg_in_dir(cfg_in_dir), .cfg_dynamic(cfg_dynamic),
        .cfg_static_sel(cfg_static_sel), .cfg_custom_port(cfg_custom_port),
        .cfg_local_port(cfg_local_port), .route_valid(route_valid),
        .route_port(route_port), .pred_oh(pred_oh)
    );

    typedef struct packed {
        logic [2:0] in_dir;
        logic [1:0] sel;
        logic [2:0] cust;
        logic [2:0] lstr;
        logic       rv;
        logic [2:0] rp;
        logic [4:0] exp_oh;
        logic [3:0] req;
    } vec_t;

    // sel: 0 straight, 1 last, 2 custom, 3 context; one-hot bit i = port code i (R1)
    localparam int NV = 28;
    localparam vec_t TBL [NV] = '{
        // R5 context history build-up from input X+
        '{3'd0, 2'd3, 3'd3, 3'd2, 1'b0, 3'd0, 5'b00010, 4'd5},
        '{3'd0, 2'd3, 3'd3, 3'd2, 1'b1, 3'd2, 5'b00010, 4'd5},
        '{3'd0, 2'd3, 3'd3, 3'd2, 1'b1, 3'd3, 5'b00010, 4'd6},
        '{3'd0, 2'd3, 3'd3, 3'd2, 1'b1, 3'd2, 5'b01000, 4'd5},
        '{3'd0, 2'd3, 3'd3, 3'd2, 1'b1, 3'd3, 5'b00100, 4'd5},
        '{3'd0, 2'd3, 3'd3, 3'd2, 1'b1, 3'd2, 5'b01000, 4'd5},
        '{3'd0, 2'd3, 3'd3, 3'd2, 1'b1, 3'd4, 5'b00010, 4'd6},
        '{3'd0, 2'd3, 3'd3, 3'd2, 1'b1, 3'd2, 5'b01000, 4'd5},
        '{3'd0, 2'd3, 3'd3, 3'd2, 1'b1, 3'd4, 5'b00100, 4'd5},
        // R5 tie goes to the lower code
        '{3'd0, 2'd3, 3'd3, 3'd2, 1'b1, 3'd2, 5'b01000, 4'd5},
        '{3'd0, 2'd3, 3'd3, 3'd2, 1'b1, 3'd4, 5'b00100, 4'd5},
        '{3'd0, 2'd3, 3'd3, 3'd2, 1'b1, 3'd2, 5'b10000, 4'd5},
        // R5 pair count saturation: a wrap would flip the argmax
        '{3'd0, 2'd3, 3'd3, 3'd2, 1'b1, 3'd4, 5'b00100, 4'd5},
        '{3'd0, 2'd3, 3'd3, 3'd2, 1'b1, 3'd2, 5'b10000, 4'd5},
        // R3 last port
        '{3'd0, 2'd1, 3'd3, 3'd2, 1'b0, 3'd0, 5'b00100, 4'd3},
        '{3'd0, 2'd1, 3'd3, 3'd2, 1'b1, 3'd0, 5'b00010, 4'd6},
        '{3'd0, 2'd1, 3'd3, 3'd2, 1'b1, 3'd3, 5'b01000, 4'd3},
        // R2 straight for every input
        '{3'd0, 2'd0, 3'd3, 3'd2, 1'b0, 3'd0, 5'b00010, 4'd2},
        '{3'd1, 2'd0, 3'd3, 3'd2, 1'b0, 3'd0, 5'b00001, 4'd1},
        '{3'd2, 2'd0, 3'd3, 3'd2, 1'b0, 3'd0, 5'b01000, 4'd2},
        '{3'd3, 2'd0, 3'd3, 3'd2, 1'b0, 3'd0, 5'b00100, 4'd2},
        '{3'd4, 2'd0, 3'd3, 3'd2, 1'b0, 3'd0, 5'b00100, 4'd2},
        '{3'd4, 2'd0, 3'd3, 3'd4, 1'b0, 3'd0, 5'b00001, 4'd2},
        // R4 custom, R6 guard
        '{3'd0, 2'd2, 3'd3, 3'd2, 1'b0, 3'd0, 5'b01000, 4'd4},
        '{3'd0, 2'd2, 3'd0, 3'd2, 1'b0, 3'd0, 5'b00010, 4'd6},
        '{3'd0, 2'd2, 3'd6, 3'd2, 1'b0, 3'd0, 5'b00010, 4'd6},
        '{3'd4, 2'd2, 3'd4, 3'd1, 1'b0, 3'd0, 5'b00010, 4'd6},
        '{3'd4, 2'd1, 3'd3, 3'd2, 1'b0, 3'd0, 5'b01000, 4'd3}
    };

    task automatic check(input logic [4:0] exp_oh, input int req, input string what);
        total++;
        if (pred_oh !== exp_oh) begin
            bad++;
            $display("FAIL R%0d %s: got %b expected %b", req, what, pred_oh, exp_oh);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        route_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        // R9: reset state, dynamic mode starts on straight despite static field
        cfg_dynamic = 1'b1;
        cfg_static_sel = 2'd2;
        do_reset();
        check(5'b00010, 9, "reset active predictor is straight");

        cfg_dynamic = 1'b0;
        do_reset();
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg_in_dir      = TBL[i].in_dir;
            cfg_static_sel  = TBL[i].sel;
            cfg_custom_port = TBL[i].cust;
            cfg_local_port  = TBL[i].lstr;
            route_valid     = TBL[i].rv;
            route_port      = TBL[i].rp;
            @(posedge clk);
            @(negedge clk);
            route_valid = 1'b0;
            check(TBL[i].exp_oh, int'(TBL[i].req), $sformatf("vector %0d", i));
        end

        // R8 dynamic selection, window of 8 cycles, 2-bit hit counters
        cfg_in_dir = 3'd0; cfg_custom_port = 3'd3; cfg_local_port = 3'd2;
        cfg_static_sel = 2'd0; cfg_dynamic = 1'b1;
        do_reset();
        route_valid = 1'b1; route_port = 3'd3;
        repeat (6) @(posedge clk);
        @(negedge clk);
        route_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cfg_custom_port = 3'd2;
        check(5'b00010, 8, "before first boundary");
        @(posedge clk);
        @(negedge clk);
        check(5'b01000, 8, "saturated tie picks last port");
        route_valid = 1'b1; route_port = 3'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        route_port = 3'd2;
        @(posedge clk);
        @(negedge clk);
        route_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(5'b00100, 8, "last port still active");
        @(posedge clk);
        @(negedge clk);
        check(5'b00010, 8, "straight wins second window");

        // R7: switching to static takes effect in the same cycle
        cfg_dynamic = 1'b0;
        cfg_static_sel = 2'd2;
        #1;
        check(5'b00100, 7, "static custom immediate");
        cfg_static_sel = 2'd1;
        #1;
        check(5'b00100, 7, "static last immediate");
        cfg_static_sel = 2'd0;
        #1;
        check(5'b00010, 7, "static straight immediate");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CYC * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule